// File: doc/BRIEF.md
# Armed Edge-Triggered Status Interrupt Collector

This block folds four framer status bits into one interrupt request: the alarm, the remote alarm indication, the sync loss and the slip indication. The request is active low with an open-drain style output. The block does not drive a pad itself. Instead, `irq_drv_o` high means "pull the line low" and low means "leave it at high impedance". A 4-bit cause register records which source raised the request.

Sources fire on edges, never on levels, and only while the block is armed. The alarm, remote alarm and sync-loss sources fire on a rising edge. Slip fires on any change of its bit. A host uses one acknowledge bit to control the block. Taking acknowledge low releases the request and clears the block. Taking acknowledge high again re-arms the block, but only if the three level-style sources are all zero at that moment. A condition that becomes active while the block is cleared can therefore never raise a request, even if it is still active when the block is armed later.

Top module: `irq_edge_agg`

## Requirements
- R1: When armed and not asserting, a 0-to-1 change of `alm_i`, `rai_i` or `los_i` asserts `irq_drv_o`. The matching cause bit is set: bit 0 is sync loss, bit 1 is slip, bit 2 is alarm, bit 3 is remote alarm.
- R2: When armed, a change of `slp_i` in either direction asserts `irq_drv_o` with cause bit 1.
- R3: A qualifying input change made before clock edge N is visible on `irq_drv_o` and `cause_o` after edge N+1, counting two registers.
- R4: When `ack_i` is low, the block is cleared. After the second edge, `irq_drv_o` is 0 and `cause_o` is 0.
- R5: The block arms only on a 0-to-1 change of `ack_i` that is sampled while `alm_i`, `rai_i` and `los_i` are all 0. If any of them is 1, arming is refused and the block stays cleared until `ack_i` goes low and rises again.
- R6: An edge that occurs while the block is cleared never raises the request, not even after the block is armed later.
- R7: A level-source edge fires only if the other two level sources are 0. A slip change fires only if all three level sources are 0. If two level sources rise together, nothing fires.
- R8: While `irq_drv_o` is asserted, `cause_o` holds its value and further edges are ignored.
- R9: After reset, the block is cleared, `irq_drv_o` is 0 and `cause_o` is 0. Inputs that are already high when reset ends create no edge.
- R10: Slip does not need to be 0 for arming. After a slip request is released, the block can be re-armed with slip still at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alm_i | input | 1 | Alarm status |
| rai_i | input | 1 | Remote alarm indication status |
| los_i | input | 1 | Sync loss status |
| slp_i | input | 1 | Slip status, toggles per event |
| ack_i | input | 1 | Host acknowledge: low clears, rising edge arms |
| irq_drv_o | output | 1 | 1 = pull the request line low, 0 = high impedance |
| cause_o | output | 4 | Latched cause, one-hot while asserting |

## Verification
The hardest case to reach from the ports is a condition that arises while the block is cleared and then outlives an arming attempt. The stimulus first raises a source with acknowledge low and then lifts acknowledge; the bench expects arming to be refused. It then drops the source and raises it again without a new acknowledge cycle, and expects no request. A separate sequence shows that a slip transition made during the clear state is forgotten once the block is armed. The bench also drives simultaneous edges: two level sources rising together, and slip changing in the same cycle as an alarm. These cases check the "others quiescent" qualification and confirm that the cause stays one-hot.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned CAUSE_W = NUM_LVL + 1;
  localparam int unsigned IN_W    = NUM_LVL + 2;
  // sample vector bit positions
  localparam int unsigned IX_LOS = 0;
  localparam int unsigned IX_ALM = 1;
  localparam int unsigned IX_RAI = 2;
  localparam int unsigned IX_SLP = 3;
  localparam int unsigned IX_ACK = 4;
  // cause bit positions
  localparam int unsigned CB_LOS = 0;
  localparam int unsigned CB_SLP = 1;
  localparam int unsigned CB_ALM = 2;
  localparam int unsigned CB_RAI = 3;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2
  } arm_st_e;
endpackage

// File: rtl/irq_agg_sampler.sv
module irq_agg_sampler #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  logic [W-1:0] cur_q, prv_q;
  logic         primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= '0;
      prv_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cur_q    <= d_i;
      // first sample after reset: previous equals current, so no edge
      prv_q    <= primed_q ? cur_q : d_i;
      primed_q <= 1'b1;
    end
  end

  assign cur_o = cur_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/irq_agg_ctl.sv
module irq_agg_ctl
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_LVL = NUM_LVL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] lvl_cur_i,
  input  logic [N_LVL-1:0] lvl_rise_i,
  input  logic             slp_chg_i,
  input  logic             ack_cur_i,
  input  logic             ack_rise_i,
  output logic             fired_o,
  output logic             armed_o,
  output logic [N_LVL:0]   cause_o
);
  arm_st_e        st_q, st_d;
  logic [N_LVL:0] cause_q, cause_d;
  logic [N_LVL-1:0] lvl_fire;
  logic           slp_fire;
  logic [N_LVL:0] fire_vec;

  for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
    logic [N_LVL-1:0] others;
    always_comb begin
      others    = lvl_cur_i;
      others[k] = 1'b0;
    end
    assign lvl_fire[k] = lvl_rise_i[k] & ~(|others);
  end

  assign slp_fire = slp_chg_i & ~(|lvl_cur_i);

  always_comb begin
    fire_vec         = '0;
    fire_vec[CB_LOS] = lvl_fire[IX_LOS];
    fire_vec[CB_SLP] = slp_fire;
    fire_vec[CB_ALM] = lvl_fire[IX_ALM];
    fire_vec[CB_RAI] = lvl_fire[IX_RAI];
  end

  always_comb begin
    st_d    = st_q;
    cause_d = cause_q;
    unique case (st_q)
      ST_CLEAR: if (ack_rise_i && !(|lvl_cur_i)) st_d = ST_ARMED;
      ST_ARMED: begin
        if (!ack_cur_i) st_d = ST_CLEAR;
        else if (|fire_vec) begin
          st_d    = ST_FIRED;
          cause_d = fire_vec;
        end
      end
      ST_FIRED: if (!ack_cur_i) begin
        st_d    = ST_CLEAR;
        cause_d = '0;
      end
      default: begin
        st_d    = ST_CLEAR;
        cause_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_CLEAR;
      cause_q <= '0;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
    end
  end

  assign fired_o = (st_q == ST_FIRED);
  assign armed_o = (st_q == ST_ARMED);
  assign cause_o = cause_q;
endmodule

// File: rtl/irq_edge_agg.sv
module irq_edge_agg
  import irq_agg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alm_i,
  input  logic               rai_i,
  input  logic               los_i,
  input  logic               slp_i,
  input  logic               ack_i,
  output logic               irq_drv_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [IN_W-1:0] raw, cur, prv;
  logic            armed_w;

  always_comb begin
    raw         = '0;
    raw[IX_LOS] = los_i;
    raw[IX_ALM] = alm_i;
    raw[IX_RAI] = rai_i;
    raw[IX_SLP] = slp_i;
    raw[IX_ACK] = ack_i;
  end

  irq_agg_sampler #(.W(IN_W)) u_smp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .cur_o (cur),
    .prv_o (prv)
  );

  irq_agg_ctl #(.N_LVL(NUM_LVL)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_cur_i (cur[NUM_LVL-1:0]),
    .lvl_rise_i(cur[NUM_LVL-1:0] & ~prv[NUM_LVL-1:0]),
    .slp_chg_i (cur[IX_SLP] ^ prv[IX_SLP]),
    .ack_cur_i (cur[IX_ACK]),
    .ack_rise_i(cur[IX_ACK] & ~prv[IX_ACK]),
    .fired_o   (irq_drv_o),
    .armed_o   (armed_w),
    .cause_o   (cause_o)
  );
endmodule

// File: rtl/irq_edge_agg_chk.sv
module irq_edge_agg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_i,
  input logic       irq_drv_o,
  input logic [3:0] cause_o,
  input logic       armed_i
);
  AST_CAUSE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_drv_o |-> $onehot(cause_o)); // R7
  AST_IDLE_NO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_drv_o |-> cause_o == 4'd0); // R4
  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_drv_o) |-> $past(armed_i)); // R6
  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_drv_o && $past(irq_drv_o)) |-> $stable(cause_o)); // R8
  AST_RELEASE_BY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_drv_o) |-> $past(ack_i, 2) == 1'b0); // R4
endmodule

bind irq_edge_agg irq_edge_agg_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_i    (ack_i),
  .irq_drv_o(irq_drv_o),
  .cause_o  (cause_o),
  .armed_i  (armed_w)
);

// File: tb/irq_edge_agg_test.sv
`timescale 1ns/1ps
module irq_edge_agg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alm = 0, rai = 0, los = 0, slp = 0, ack = 0;
  logic irq;
  logic [3:0] cause;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [3:0] C_LOS = 4'b0001, C_SLP = 4'b0010,
                         C_ALM = 4'b0100, C_RAI = 4'b1000;

  always #2.5 clk = ~clk;

  irq_edge_agg uut (
    .clk_i(clk), .rst_ni(rst_n), .alm_i(alm), .rai_i(rai), .los_i(los),
    .slp_i(slp), .ack_i(ack), .irq_drv_o(irq), .cause_o(cause)
  );

  // drive at negedge, then wait through two edges (R3 latency)
  task automatic put(input logic a, r, l, s, k);
    @(negedge clk);
    alm = a; rai = r; los = l; slp = s; ack = k;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic ei, input logic [3:0] ec);
    total++;
    if (irq !== ei || cause !== ec) begin
      bad++;
      $display("FAIL %s: irq=%b cause=%b expected irq=%b cause=%b",
               req, irq, cause, ei, ec);
    end
  endtask

  task automatic rearm(input logic s);
    put(0, 0, 0, s, 0);
    put(0, 0, 0, s, 1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: expired expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: inputs high across reset give no edge
    alm = 1; slp = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset", 0, 4'd0);
    put(0, 0, 0, 0, 0);
    chk("R9 after drop", 0, 4'd0);

    // R1 sweep over each level source, plus R4 release
    for (int k = 0; k < 3; k++) begin
      logic [3:0] exp_c;
      rearm(0);
      chk("R5 armed idle", 0, 4'd0);
      exp_c = (k == 0) ? C_LOS : (k == 1) ? C_ALM : C_RAI;
      put(k == 1, k == 2, k == 0, 0, 1);
      chk("R1 level rise", 1, exp_c);
      put(0, 0, 0, 0, 1);
      chk("R8 hold on fall", 1, exp_c);
      put(0, 0, 0, 0, 0);
      chk("R4 ack low clears", 0, 4'd0);
    end

    // R3: exactly two edges of latency
    rearm(0);
    @(negedge clk); alm = 1;
    @(negedge clk);
    chk("R3 one edge not yet", 0, 4'd0);
    @(negedge clk);
    chk("R3 second edge", 1, C_ALM);
    put(0, 0, 0, 0, 0);

    // R2: slip rise then slip fall, R10 re-arm with slip high
    rearm(0);
    put(0, 0, 0, 1, 1);
    chk("R2 slip rise", 1, C_SLP);
    rearm(1);
    chk("R10 armed with slip high", 0, 4'd0);
    put(0, 0, 0, 0, 1);
    chk("R2 slip fall", 1, C_SLP);
    put(0, 0, 0, 0, 0);

    // R8: further edge ignored while asserting
    rearm(0);
    put(0, 0, 0, 1, 1);
    put(0, 0, 1, 1, 1);
    chk("R8 los ignored while asserting", 1, C_SLP);
    put(0, 0, 0, 1, 0);
    chk("R4 cleared", 0, 4'd0);

    // R7: two level sources rising together do not fire
    rearm(1);
    put(1, 1, 0, 1, 1);
    chk("R7 double rise", 0, 4'd0);
    // R7: slip change with alarm high does not fire
    put(1, 1, 0, 0, 1);
    chk("R7 slip blocked", 0, 4'd0);
    put(0, 0, 0, 0, 0);

    // R7: alarm rise with simultaneous slip change -> alarm only
    rearm(0);
    put(1, 0, 0, 1, 1);
    chk("R7 alarm over slip", 1, C_ALM);
    put(0, 0, 0, 1, 0);

    // R5/R6: source raised while cleared, arming refused
    put(0, 0, 1, 1, 0);
    put(0, 0, 1, 1, 1);
    chk("R6 active before arm", 0, 4'd0);
    put(0, 0, 0, 1, 1);
    put(0, 0, 1, 1, 1);
    chk("R5 refused arm stays clear", 0, 4'd0);
    put(0, 0, 0, 0, 1);
    chk("R6 slip while clear", 0, 4'd0);

    // R6: slip edge during clear forgotten after arming
    put(0, 0, 0, 1, 0);
    put(0, 0, 0, 1, 1);
    chk("R6 past slip edge", 0, 4'd0);
    put(0, 0, 0, 0, 1);
    chk("R5 armed after retry", 1, C_SLP);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule